// File: doc/BRIEF.md
# Tiled RAM with Gated Row Strobes

This block assembles a wide, deep RAM out of a grid of identical one-bit-wide sub-memories. Grid rows multiply the number of addressable words, and grid columns multiply the word width. The most significant address bits are decoded into a one-hot row select. Every row receives its own write strobe and its own output strobe, each formed by ANDing a global strobe with that row's select line. The remaining address bits go unchanged to every sub-memory. Column j of each row holds data bit j.

A parameter chooses the interface. The split form has separate global write and output enables. The write-only form has no output enable: a high write enable writes, a low write enable reads, and the output-enable pin is ignored. Read data is registered, so it appears one clock after the request. A row whose output strobe is low drives zeros onto the shared read path, which means the read word is zero whenever no row is enabled.

Top module: `tiled_ram`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rdata` becomes zero on that edge.
- R2: A rising edge with the write strobe active stores `wdata` into row `addr[AW-1:SUB_AW]` at offset `addr[SUB_AW-1:0]`. Bit j of `wdata` goes to column j. A word is changed only by a write to its own address.
- R3: In split mode (MODE = IF_SPLIT), `oe` high at a rising edge makes `rdata` equal to the word stored at `addr` one cycle later.
- R4: When no read is requested at a rising edge (`oe` low in split mode, `we` high in write-only mode), `rdata` is zero after that edge.
- R5: At most one row's write strobe is active in any cycle, so a write to one row never alters any word in another row.
- R6: In split mode, `we` and `oe` high together on the same address return the word held before the write. The next read returns the new word.
- R7: In write-only mode (MODE = IF_WE_ONLY), `we` low is a read of `addr` with one cycle of latency, `we` high is a write, and `oe` has no effect on either.
- R8: At most one row's output strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | AW | Word address; upper bits choose the row, lower bits the offset |
| wdata | input | COLS | Write data, one bit per column |
| we | input | 1 | Global write enable (in write-only mode, also low = read) |
| oe | input | 1 | Global output enable (split mode only; ignored otherwise) |
| rdata | output | COLS | Registered read data, zero when no row is enabled |

## Verification
In split mode, a write and a read can land on the same row and the same offset in one cycle. The bench provokes this by raising `we` and `oe` together on several addresses, each with data that differs from the stored word. It judges the result by requiring the old word on `rdata` one cycle later and the new word on a plain read after that. Writes into one row are then followed by a sweep over the full address space of the sub-memory grid, which confirms that every other row kept its contents.

// File: rtl/tiled_ram_pkg.sv
package tiled_ram_pkg;

  typedef enum logic {
    IF_SPLIT   = 1'b0,
    IF_WE_ONLY = 1'b1
  } ifmode_e;

endpackage

// File: rtl/tram_row_decoder.sv
module tram_row_decoder #(
  parameter int ROWS = 4,
  localparam int RB = $clog2(ROWS)
) (
  input  logic [RB-1:0]   idx,
  output logic [ROWS-1:0] onehot
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign onehot[r] = (idx == RB'(r));
  end

endmodule

// File: rtl/tram_strobe_gate.sv
module tram_strobe_gate #(
  parameter int                     ROWS = 4,
  parameter tiled_ram_pkg::ifmode_e MODE = tiled_ram_pkg::IF_SPLIT
) (
  input  logic            we,
  input  logic            oe,
  input  logic [ROWS-1:0] sel,
  output logic [ROWS-1:0] row_we,
  output logic [ROWS-1:0] row_oe
);

  assign row_we = sel & {ROWS{we}};

  if (MODE == tiled_ram_pkg::IF_SPLIT) begin : g_split
    assign row_oe = sel & {ROWS{oe}};
  end else begin : g_we_only
    logic unused_oe;
    assign unused_oe = oe;
    assign row_oe    = sel & {ROWS{~we}};
  end

endmodule

// File: rtl/tram_bit_mem.sv
module tram_bit_mem #(
  parameter int SUB_AW = 4,
  localparam int DEPTH = 1 << SUB_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [SUB_AW-1:0] a,
  input  logic              d,
  output logic              q
);

  logic cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[a] <= d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (re) begin
      q <= cells[a];
    end else begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/tram_col_merge.sv
module tram_col_merge #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic [ROWS-1:0][COLS-1:0] q_rows,
  output logic [COLS-1:0]           y
);

  always_comb begin
    y = '0;
    for (int r = 0; r < ROWS; r++) begin
      y = y | q_rows[r];
    end
  end

endmodule

// File: rtl/tiled_ram.sv
module tiled_ram #(
  parameter int                     ROWS   = 4,
  parameter int                     COLS   = 4,
  parameter int                     SUB_AW = 20,
  parameter tiled_ram_pkg::ifmode_e MODE   = tiled_ram_pkg::IF_SPLIT,
  localparam int                    RB     = $clog2(ROWS),
  localparam int                    AW     = SUB_AW + RB
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [COLS-1:0] wdata,
  input  logic            we,
  input  logic            oe,
  output logic [COLS-1:0] rdata
);

  logic [ROWS-1:0]           row_sel;
  logic [ROWS-1:0]           row_we;
  logic [ROWS-1:0]           row_oe;
  logic [ROWS-1:0][COLS-1:0] row_q;

  tram_row_decoder #(.ROWS(ROWS)) u_dec (
    .idx    (addr[AW-1:SUB_AW]),
    .onehot (row_sel)
  );

  tram_strobe_gate #(.ROWS(ROWS), .MODE(MODE)) u_gate (
    .we     (we),
    .oe     (oe),
    .sel    (row_sel),
    .row_we (row_we),
    .row_oe (row_oe)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      tram_bit_mem #(.SUB_AW(SUB_AW)) u_cell (
        .clk (clk),
        .rst (rst),
        .we  (row_we[r]),
        .re  (row_oe[r]),
        .a   (addr[SUB_AW-1:0]),
        .d   (wdata[c]),
        .q   (row_q[r][c])
      );
    end
  end

  tram_col_merge #(.ROWS(ROWS), .COLS(COLS)) u_merge (
    .q_rows (row_q),
    .y      (rdata)
  );

endmodule

// File: rtl/tiled_ram_chk.sv
module tiled_ram_chk #(
  parameter int                     ROWS   = 4,
  parameter int                     COLS   = 4,
  parameter int                     SUB_AW = 20,
  parameter tiled_ram_pkg::ifmode_e MODE   = tiled_ram_pkg::IF_SPLIT,
  localparam int                    RB     = $clog2(ROWS),
  localparam int                    AW     = SUB_AW + RB
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   addr,
  input logic            we,
  input logic            oe,
  input logic [COLS-1:0] rdata,
  input logic [ROWS-1:0] row_we,
  input logic [ROWS-1:0] row_oe
);

  logic rd_req;
  assign rd_req = (MODE == tiled_ram_pkg::IF_SPLIT) ? oe : ~we;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (rdata == '0)); // R1

  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
    (|row_we) |-> (we && row_we[addr[AW-1:SUB_AW]])); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (rdata == '0)); // R4

  AST_WE_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_we)); // R5

  AST_OE_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_oe)); // R8

  if (MODE == tiled_ram_pkg::IF_WE_ONLY) begin : g_we_only
    AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (rst)
      !((|row_we) && (|row_oe))); // R7
  end

endmodule

bind tiled_ram tiled_ram_chk #(
  .ROWS(ROWS), .COLS(COLS), .SUB_AW(SUB_AW), .MODE(MODE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .oe(oe),
  .rdata(rdata), .row_we(row_we), .row_oe(row_oe)
);

// File: tb/tiled_ram_test.sv
module tiled_ram_test;

  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int SUB_AW = 4;
  localparam int AW     = SUB_AW + $clog2(ROWS);
  localparam int WORDS  = 1 << AW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   addr = '0;
  logic [COLS-1:0] wdata = '0;
  logic            we_d = 1'b0, oe_d = 1'b0;
  logic            we_r = 1'b0, oe_r = 1'b0;
  logic [COLS-1:0] rdata_d, rdata_r;

  logic [COLS-1:0] mdl_d [WORDS];
  logic [COLS-1:0] mdl_r [WORDS];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tiled_ram #(.ROWS(ROWS), .COLS(COLS), .SUB_AW(SUB_AW),
              .MODE(tiled_ram_pkg::IF_SPLIT)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .we(we_d), .oe(oe_d), .rdata(rdata_d));

  tiled_ram #(.ROWS(ROWS), .COLS(COLS), .SUB_AW(SUB_AW),
              .MODE(tiled_ram_pkg::IF_WE_ONLY)) uut_r (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .we(we_r), .oe(oe_r), .rdata(rdata_r));

  task automatic check(input string tag, input logic [COLS-1:0] act,
                       input logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic cyc(input int a, input logic [COLS-1:0] d,
                     input logic wd, input logic od,
                     input logic wr, input logic orr);
    addr  = AW'(a);
    wdata = d;
    we_d  = wd; oe_d = od;
    we_r  = wr; oe_r = orr;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [COLS-1:0] pat(input int a, input int k);
    return COLS'(a * 5 + k * 7 + 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R1 reset split", rdata_d, '0);
    check("R1 reset we-only", rdata_r, '0);
    rst = 1'b0;

    // Fill both instances; no read requested on either.
    for (int a = 0; a < WORDS; a++) begin
      mdl_d[a] = pat(a, 0);
      mdl_r[a] = pat(a, 1);
      addr = AW'(a);
      cyc(a, mdl_d[a], 1'b1, 1'b0, 1'b0, 1'b0);
      check("R4 split idle during write", rdata_d, '0);
      cyc(a, mdl_r[a], 1'b0, 1'b0, 1'b1, 1'b1);
      check("R7 we-only write with oe ignored", rdata_r, '0);
    end

    // Full read-back sweep.
    for (int a = 0; a < WORDS; a++) begin
      cyc(a, '1, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R3 R2 split read", rdata_d, mdl_d[a]);
      check("R7 we-only read oe low", rdata_r, mdl_r[a]);
      cyc(a, '1, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R7 we-only read oe high", rdata_r, mdl_r[a]);
    end

    // Rewrite one row at a time; verify every other row kept its contents.
    for (int r = 0; r < ROWS; r++) begin
      for (int o = 0; o < (1 << SUB_AW); o++) begin
        int a = r * (1 << SUB_AW) + o;
        mdl_d[a] = ~pat(a, r + 2);
        cyc(a, mdl_d[a], 1'b1, 1'b0, 1'b0, 1'b0);
      end
      for (int a = 0; a < WORDS; a++) begin
        cyc(a, '0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 R2 row isolation", rdata_d, mdl_d[a]);
      end
    end

    // Write and read on the same address in one cycle.
    for (int a = 0; a < WORDS; a += 7) begin
      logic [COLS-1:0] nv;
      nv = ~mdl_d[a];
      cyc(a, nv, 1'b1, 1'b1, 1'b0, 1'b0);
      check("R6 same-cycle read returns old", rdata_d, mdl_d[a]);
      mdl_d[a] = nv;
      cyc(a, '0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R6 following read returns new", rdata_d, mdl_d[a]);
    end

    // Strobes low: nothing written, nothing read.
    cyc(5, ~mdl_d[5], 1'b0, 1'b0, 1'b1, 1'b0);
    check("R4 split no oe gives zero", rdata_d, '0);
    mdl_r[5] = ~mdl_d[5];
    cyc(5, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R2 no write without we", rdata_d, mdl_d[5]);
    check("R7 we-only write then read", rdata_r, mdl_r[5]);

    // Reset clears a non-zero read register.
    cyc(9, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    cyc(9, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R1 reset clears rdata", rdata_d, '0);
    rst = 1'b0;
    cyc(9, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R1 contents survive reset", rdata_d, mdl_d[9]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule